// File: doc/BRIEF.md
# Configurable CRC and Checksum Engine

This block computes a running cyclic redundancy check, or a 16-bit ones-complement checksum, over a stream of words that software writes to a data register. A control register sets the operation and its options:
- the polynomial, or checksum mode;
- where the starting value comes from;
- whether each write carries a full word or one byte;
- how the input is reordered and bit-reversed;
- how the result is inverted and bit-reversed.

A seed register supplies the starting value and then always holds the raw running value. A separate result register returns the post-processed value.

Every data write is absorbed in the cycle it is presented, so writes may arrive back to back. Reads use the same address port. Read data is registered and appears one cycle after the address is presented.

Top module: `crc_csum_engine`

## Requirements
- R1: After reset the control, seed and result registers all read as zero.
- R2: Control bits [3:0] select the operation. The CRC codes are 0000 (poly 0x8005, 16-bit), 0001 (poly 0x1021, 16-bit), 0010 (poly 0x04C11DB7, 32-bit) and 0011 (poly 0x1EDC6F41, 32-bit). The CRC is shifted MSB first with no reflection, starting from the highest input bit of the write.
- R3: Code 1000 selects the checksum. Each 32-bit write adds its upper halfword and then its lower halfword into a 16-bit accumulator with end-around carry; an 8-bit write adds the zero-extended byte.
- R4: Control bits [14:13] pick the start value used by the next data write. 10 means all zeros and 11 means all ones within the active width. 00 and 01 both mean the seed register.
- R5: A data write clears control bits [14:13] to 00, so later writes continue from the running value until software writes the control register again.
- R6: Control bit 12 set means each data write processes only bits [7:0] of the shaped input word; clear means all 32 bits.
- R7: Input shaping is applied in this order. Bit 4 swaps the bytes within each halfword. Bit 5 then swaps the two halfwords. Bit 7 then bit-reverses every byte.
- R8: A write to the seed register (offset 0x10) loads it. After every data write the seed register holds the raw CRC or checksum. In the 16-bit modes its bits [31:16] are zero.
- R9: The result register (offset 0x18) returns the raw value after two steps. First, control bit 9 inverts it within the active width. Then control bit 8 bit-reverses each byte. Bits above the active width read as zero.
- R10: Offsets are control 0x00, seed 0x10, data in 0x14 and result 0x18. Read data appears one cycle after the address is presented. The data-in register reads as zero. The control register reads back only its defined bits (mask 0x73BF).
- R11: A data write with an undefined operation code leaves the seed register unchanged, but still clears the init field.
- R12: Data writes on consecutive cycles are each applied in full. The value read on the cycle after the last write reflects every write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe for the register at `addr` |
| addr | input | ADDR_W | Register offset for write and read |
| wr_data | input | 32 | Write data |
| rd_data | output | 32 | Registered read data for the previous cycle's `addr` |

## Verification
The bench sweeps every operation code against every combination of input swap, input bit reversal, size, output inversion and output bit reversal. It cycles through the three init choices and uses pseudo-random seeds and data. Each case is compared with an arithmetic model.

Known check values for the standard nine-digit ASCII string catch a design that shifts LSB first or uses the wrong polynomial. Reading the control register after a data write catches an init field that fails to self-clear; such a design would restart from the seed on every write. The upper result bits in the 16-bit modes expose state that leaks outside the active width. Back-to-back writes, an undefined operation code and init code 01 cover a lost write, a corrupted seed and a misdecoded init field.

// File: rtl/crc_pkg.sv
package crc_pkg;
  localparam int DW = 32;

  // register offsets (software visible)
  localparam logic [7:0] OFS_CTRL = 8'h00;
  localparam logic [7:0] OFS_SEED = 8'h10;
  localparam logic [7:0] OFS_DIN  = 8'h14;
  localparam logic [7:0] OFS_RES  = 8'h18;

  // operation codes
  localparam logic [3:0] OP_P8005 = 4'b0000;
  localparam logic [3:0] OP_P1021 = 4'b0001;
  localparam logic [3:0] OP_P04C1 = 4'b0010;
  localparam logic [3:0] OP_P1EDC = 4'b0011;
  localparam logic [3:0] OP_SUM   = 4'b1000;

  localparam logic [31:0] CTRL_MASK = 32'h0000_73BF;

  typedef struct packed {
    logic [1:0] init;   // [14:13]
    logic       size8;  // [12]
    logic       oinv;   // [9]
    logic       obr;    // [8]
    logic       ibr;    // [7]
    logic [1:0] swap;   // [5:4]
    logic [3:0] op;     // [3:0]
  } ctrl_t;

  function automatic ctrl_t ctrl_unpack(input logic [31:0] w);
    ctrl_t c;
    c.init  = w[14:13];
    c.size8 = w[12];
    c.oinv  = w[9];
    c.obr   = w[8];
    c.ibr   = w[7];
    c.swap  = w[5:4];
    c.op    = w[3:0];
    return c;
  endfunction

  function automatic logic [31:0] ctrl_pack(input ctrl_t c);
    logic [31:0] w;
    w = '0;
    w[14:13] = c.init;
    w[12]    = c.size8;
    w[9]     = c.oinv;
    w[8]     = c.obr;
    w[7]     = c.ibr;
    w[5:4]   = c.swap;
    w[3:0]   = c.op;
    return w;
  endfunction

  function automatic logic op_is_wide(input logic [3:0] op);
    return (op == OP_P04C1) || (op == OP_P1EDC);
  endfunction
endpackage

// File: rtl/crc_in_shape.sv
module crc_in_shape #(
  parameter int W = 32
) (
  input  logic         ibr,
  input  logic [1:0]   swap,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  localparam int NB = W / 8;

  logic [W-1:0] s0, s1, rev;

  always_comb begin
    s0 = din;
    if (swap[0]) s0 = {din[23:16], din[31:24], din[7:0], din[15:8]};
    s1 = s0;
    if (swap[1]) s1 = {s0[15:0], s0[31:16]};
  end

  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign rev[b*8+k] = s1[b*8+7-k];
    end
  end

  assign dout = ibr ? rev : s1;
endmodule

// File: rtl/crc_core_step.sv
module crc_core_step import crc_pkg::*; #(
  parameter int W = 32
) (
  input  logic [3:0]   op,
  input  logic         size8,
  input  logic [W-1:0] start,
  input  logic [W-1:0] din,
  output logic [W-1:0] nxt,
  output logic         ok
);
  logic [W-1:0] poly, wm, s;
  logic [4:0]   top;
  logic         fb;
  logic [16:0]  sum;
  logic [15:0]  acc;
  int           nb;

  always_comb begin
    ok   = 1'b1;
    wm   = 32'h0000_FFFF;
    top  = 5'd15;
    poly = '0;
    case (op)
      OP_P8005: poly = 32'h0000_8005;
      OP_P1021: poly = 32'h0000_1021;
      OP_P04C1: begin poly = 32'h04C1_1DB7; wm = '1; top = 5'd31; end
      OP_P1EDC: begin poly = 32'h1EDC_6F41; wm = '1; top = 5'd31; end
      OP_SUM:   ;
      default:  ok = 1'b0;
    endcase
    nb  = size8 ? 8 : 32;
    s   = start & wm;
    acc = s[15:0];
    sum = '0;
    fb  = 1'b0;
    if (op == OP_SUM) begin
      if (size8) begin
        sum = {1'b0, acc} + {9'b0, din[7:0]};
        acc = sum[15:0] + {15'b0, sum[16]};
      end else begin
        sum = {1'b0, acc} + {1'b0, din[31:16]};
        acc = sum[15:0] + {15'b0, sum[16]};
        sum = {1'b0, acc} + {1'b0, din[15:0]};
        acc = sum[15:0] + {15'b0, sum[16]};
      end
      s = {16'b0, acc};
    end else begin
      for (int i = W - 1; i >= 0; i--) begin
        if (i < nb) begin
          fb = s[top] ^ din[i];
          s  = (s << 1) & wm;
          if (fb) s = s ^ poly;
        end
      end
    end
    nxt = ok ? s : start;
  end
endmodule

// File: rtl/crc_out_shape.sv
module crc_out_shape #(
  parameter int W = 32
) (
  input  logic         oinv,
  input  logic         obr,
  input  logic         wide,
  input  logic [W-1:0] raw,
  output logic [W-1:0] res
);
  localparam int NB = W / 8;

  logic [W-1:0] wm, inv, rev;

  assign wm  = wide ? '1 : {{(W-16){1'b0}}, 16'hFFFF};
  assign inv = oinv ? ((raw & wm) ^ wm) : (raw & wm);

  for (genvar b = 0; b < NB; b++) begin : g_byte
    for (genvar k = 0; k < 8; k++) begin : g_bit
      assign rev[b*8+k] = inv[b*8+7-k];
    end
  end

  assign res = obr ? rev : inv;
endmodule

// File: rtl/crc_csum_engine.sv
module crc_csum_engine import crc_pkg::*; #(
  parameter int ADDR_W = 5
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DW-1:0]     wr_data,
  output logic [DW-1:0]     rd_data
);
  localparam logic [ADDR_W-1:0] A_CTRL = OFS_CTRL[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_SEED = OFS_SEED[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_DIN  = OFS_DIN[ADDR_W-1:0];
  localparam logic [ADDR_W-1:0] A_RES  = OFS_RES[ADDR_W-1:0];

  ctrl_t          ctrl_q;
  logic [DW-1:0]  state_q, rd_q;
  logic [DW-1:0]  shaped, start, nxt, post, wm;
  logic           wr_ctrl, wr_seed, wr_din, wide, ok;

  assign wr_ctrl = wr_en && (addr == A_CTRL);
  assign wr_seed = wr_en && (addr == A_SEED);
  assign wr_din  = wr_en && (addr == A_DIN);
  assign wide    = op_is_wide(ctrl_q.op);
  assign wm      = wide ? '1 : 32'h0000_FFFF;

  always_comb begin
    case (ctrl_q.init)
      2'b10:   start = '0;
      2'b11:   start = wm;
      default: start = state_q;
    endcase
  end

  crc_in_shape #(.W(DW)) u_in (
    .ibr(ctrl_q.ibr), .swap(ctrl_q.swap), .din(wr_data), .dout(shaped)
  );

  crc_core_step #(.W(DW)) u_step (
    .op(ctrl_q.op), .size8(ctrl_q.size8), .start(start), .din(shaped),
    .nxt(nxt), .ok(ok)
  );

  crc_out_shape #(.W(DW)) u_out (
    .oinv(ctrl_q.oinv), .obr(ctrl_q.obr), .wide(wide), .raw(state_q), .res(post)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      ctrl_q  <= '0;
      state_q <= '0;
    end else begin
      if (wr_ctrl) ctrl_q <= ctrl_unpack(wr_data);
      if (wr_seed) state_q <= wr_data;
      if (wr_din) begin
        ctrl_q.init <= 2'b00;
        if (ok) state_q <= nxt;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_q <= '0;
    end else begin
      case (addr)
        A_CTRL:  rd_q <= ctrl_pack(ctrl_q);
        A_SEED:  rd_q <= state_q;
        A_RES:   rd_q <= post;
        default: rd_q <= '0;
      endcase
    end
  end

  assign rd_data = rd_q;

  // R5: init field self-clears after any data write
  a_r5_init_clears: assert property (@(posedge clk) disable iff (rst)
    wr_din |=> (ctrl_q.init == 2'b00));

  // R8: narrow modes keep upper state bits at zero after a data write
  a_r8_narrow_upper_zero: assert property (@(posedge clk) disable iff (rst)
    (wr_din && ok && !wide) |=> (state_q[31:16] == 16'h0000));

  // R11: undefined operation leaves the running value alone
  a_r11_bad_op_holds: assert property (@(posedge clk) disable iff (rst)
    (wr_din && !ok) |=> $stable(state_q));

  // R10: data-in offset reads as zero
  a_r10_din_reads_zero: assert property (@(posedge clk) disable iff (rst)
    (addr == A_DIN) |=> (rd_data == '0));

  // R12: without a write neither register moves
  a_r12_idle_hold: assert property (@(posedge clk) disable iff (rst)
    !wr_en |=> ($stable(state_q) && $stable(ctrl_q)));
endmodule

// File: tb/crc_csum_engine_tb.sv
module crc_csum_engine_tb;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 150000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        wr_en = 1'b0;
  logic [4:0]  addr = '0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int total = 0;
  int bad   = 0;
  int cyc   = 0;
  logic [31:0] lcg = 32'h1234_5678;

  crc_csum_engine #(.ADDR_W(5)) u_dut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .addr(addr),
    .wr_data(wr_data), .rd_data(rd_data)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == WATCHDOG) begin
      bad = bad + 1;
      total = total + 1;
      $display("FAIL watchdog: run hung, actual=%0d expected<%0d cycles", cyc, WATCHDOG);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  task automatic wr(input logic [4:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wr_data = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [4:0] a, output logic [31:0] v);
    wr_en = 1'b0; addr = a;
    @(negedge clk);
    v = rd_data;
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    total = total + 1;
    if (act !== exp) begin
      bad = bad + 1;
      $display("FAIL %s: actual=%08h expected=%08h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] next_rand();
    lcg = lcg * 32'd1664525 + 32'd1013904223;
    return lcg;
  endfunction

  function automatic logic [31:0] brev_bytes(input logic [31:0] x);
    logic [31:0] r;
    for (int i = 0; i < 32; i++) r[(i/8)*8 + 7 - (i%8)] = x[i];
    return r;
  endfunction

  function automatic logic [31:0] m_shape(input logic [31:0] d, input logic [31:0] c);
    logic [31:0] r;
    r = d;
    if (c[4]) r = {r[23:16], r[31:24], r[7:0], r[15:8]};
    if (c[5]) r = {r[15:0], r[31:16]};
    if (c[7]) r = brev_bytes(r);
    return r;
  endfunction

  function automatic logic m_wide(input logic [3:0] op);
    return op == 4'd2 || op == 4'd3;
  endfunction

  function automatic logic [31:0] m_mask(input logic [3:0] op);
    return m_wide(op) ? 32'hFFFF_FFFF : 32'h0000_FFFF;
  endfunction

  function automatic logic [15:0] ones_add(input logic [15:0] a, input logic [15:0] b);
    logic [31:0] t;
    t = {16'b0, a} + {16'b0, b};
    t = (t & 32'hFFFF) + (t >> 16);
    return t[15:0];
  endfunction

  function automatic logic [31:0] m_step(input logic [31:0] st, input logic [31:0] d,
                                         input logic [31:0] c);
    logic [3:0]  op;
    logic [31:0] poly, m, s;
    int          w, n;
    op = c[3:0];
    m = m_mask(op);
    w = m_wide(op) ? 32 : 16;
    n = c[12] ? 8 : 32;
    s = st & m;
    case (op)
      4'd0: poly = 32'h8005;
      4'd1: poly = 32'h1021;
      4'd2: poly = 32'h04C11DB7;
      4'd3: poly = 32'h1EDC6F41;
      default: poly = 0;
    endcase
    if (op == 4'd8) begin
      if (c[12]) s = {16'b0, ones_add(s[15:0], {8'b0, d[7:0]})};
      else s = {16'b0, ones_add(ones_add(s[15:0], d[31:16]), d[15:0])};
      return s;
    end
    for (int i = n - 1; i >= 0; i--) begin
      if (s[w-1] ^ d[i]) s = ((s << 1) ^ poly) & m;
      else s = (s << 1) & m;
    end
    return s;
  endfunction

  function automatic logic [31:0] m_post(input logic [31:0] st, input logic [31:0] c);
    logic [31:0] r, m;
    m = m_mask(c[3:0]);
    r = st & m;
    if (c[9]) r = r ^ m;
    if (c[8]) r = brev_bytes(r);
    return r;
  endfunction

  logic [31:0] v;
  logic [31:0] ops [5] = '{32'd0, 32'd1, 32'd2, 32'd3, 32'd8};
  logic [7:0]  digits [9] = '{8'h31, 8'h32, 8'h33, 8'h34, 8'h35, 8'h36, 8'h37, 8'h38, 8'h39};

  initial begin
    @(negedge clk); @(negedge clk);
    rst = 1'b0;

    // R1: reset values
    rd(5'h00, v); check("R1 ctrl", v, 0);
    rd(5'h10, v); check("R1 seed", v, 0);
    rd(5'h18, v); check("R1 result", v, 0);

    // R2: known check values over ASCII "123456789" in byte mode
    wr(5'h00, 32'h0000_7002);
    for (int i = 0; i < 9; i++) wr(5'h14, {24'h0, digits[i]});
    rd(5'h10, v); check("R2 poly 04C11DB7 check value", v, 32'h0376_E6E7);
    wr(5'h00, 32'h0000_7001);
    for (int i = 0; i < 9; i++) wr(5'h14, {24'h0, digits[i]});
    rd(5'h10, v); check("R2 poly 1021 check value", v, 32'h0000_29B1);
    wr(5'h00, 32'h0000_5000);
    for (int i = 0; i < 9; i++) wr(5'h14, {24'h0, digits[i]});
    rd(5'h10, v); check("R2 poly 8005 check value", v, 32'h0000_FEE8);

    // R10: data-in reads zero; ctrl keeps only defined bits
    rd(5'h14, v); check("R10 din reads zero", v, 0);
    wr(5'h00, 32'hFFFF_FFFF);
    rd(5'h00, v); check("R10 ctrl mask", v, 32'h0000_73BF);

    // R11: undefined op keeps seed, still clears init
    wr(5'h00, 32'h0000_6005);
    wr(5'h10, 32'h0000_1234);
    wr(5'h14, 32'hDEAD_BEEF);
    rd(5'h10, v); check("R11 seed unchanged", v, 32'h0000_1234);
    rd(5'h00, v); check("R11 init cleared", v, 32'h0000_0005);

    // R4: init code 01 behaves like seed
    wr(5'h00, 32'h0000_2002);
    wr(5'h10, 32'hCAFE_F00D);
    wr(5'h14, 32'h0102_0304);
    rd(5'h10, v);
    check("R4 init 01 uses seed", v, m_step(32'hCAFE_F00D, 32'h0102_0304, 32'h2002));

    // R12: back-to-back data writes
    begin
      logic [31:0] st;
      wr(5'h00, 32'h0000_6003);
      st = 32'hFFFF_FFFF;
      for (int i = 0; i < 6; i++) begin
        logic [31:0] d;
        d = next_rand();
        st = m_step(st, d, 32'h0000_0003);
        wr(5'h14, d);
      end
      rd(5'h10, v); check("R12 back-to-back", v, st);
    end

    // R2 R3 R4 R5 R6 R7 R8 R9: sweep over all ops and option combinations
    for (int t = 0; t < 5; t++) begin
      for (int o = 0; o < 64; o++) begin
        logic [31:0] c, seed, st;
        logic [1:0]  ini;
        ini = ((t + o) % 3 == 0) ? 2'b00 : (((t + o) % 3 == 1) ? 2'b10 : 2'b11);
        c = ops[t];
        c[7] = o[0]; c[5:4] = o[2:1]; c[9] = o[3]; c[8] = o[4]; c[12] = o[5];
        c[14:13] = ini;
        seed = next_rand();
        wr(5'h10, seed);
        wr(5'h00, c);
        st = (ini == 2'b10) ? 32'h0 : ((ini == 2'b11) ? m_mask(c[3:0]) : seed);
        for (int k = 0; k < 3; k++) begin
          logic [31:0] d;
          d = next_rand();
          st = m_step(st, m_shape(d, c), c);
          wr(5'h14, d);
        end
        rd(5'h10, v);
        check(c[3] ? "R3 R6 R7 R8 checksum raw" : "R2 R6 R7 R8 crc raw", v, st);
        rd(5'h18, v);
        check("R9 post-processed result", v, m_post(st, c));
        c[14:13] = 2'b00;
        rd(5'h00, v);
        check("R5 init self-cleared", v, c);
      end
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule